// File: doc/BRIEF.md
# Receive Error Statistics with Wrap Interrupts

This block keeps the receive-side error statistics of an Ethernet MAC. Single-cycle event pulses from the receive path bump four narrow 8-bit counters: CRC errors, framing errors, overflow errors and frames missed for lack of a free receive descriptor. The first three are packed side by side into one readable register. The missed-frame count has a register of its own.

Reading a counter register clears the counters it contains, so software accumulates deltas. Whenever a counter rolls over past 255 it sets its own sticky status bit, and software credits that counter with 256 events. The same status register also records receive-done and transmit-done pulses. Status bits are cleared by writing ones. An enable register gates a single interrupt output: one enable bit for receive-done, one for transmit-done, and one shared by all four wrap bits.

The register port is a simple strobe interface with a 2-bit word address. Read data is combinational and is valid in the cycle the read strobe is high.

Top module: `rx_err_stats`

## Requirements
- R1: Address 2 reads the packed error register: CRC count in bits 7:0, framing count in bits 15:8, overflow count in bits 23:16, and zero in bits 31:24.
- R2: Address 3 reads the missed-frame count in bits 7:0, with the upper bits zero.
- R3: Each event pulse adds one to its counter. An event that arrives while the counter is at 255 wraps it to 0 and sets that counter's status bit: bit 2 for missed frames, bit 3 for CRC, bit 4 for framing, bit 5 for overflow.
- R4: Status (address 0) bits are cleared by writing a one to them, and writing a zero leaves a bit unchanged. If a bit's set event and its clearing write fall in the same cycle, the bit ends up set.
- R5: A read of address 2 clears the three packed counters, and a read of address 3 clears the missed-frame counter. An event in the same cycle as such a read leaves that counter at 1. The read returns the value from before the clear.
- R6: The enable register (address 1, read/write) has bit 0 for receive-done, bit 1 for transmit-done and bit 2 shared by status bits 5:2. irq_o is high exactly when an enabled status bit is set.
- R7: A rx_done_i pulse sets status bit 0 and a tx_done_i pulse sets status bit 1.
- R8: After reset, all counters, status bits and enables are zero and irq_o is low.
- R9: reg_rdata_o is the addressed register while reg_rd_i is high and zero otherwise. Addresses 0 and 1 read back status and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_err_i | input | 1 | CRC error event pulse |
| frame_err_i | input | 1 | Framing error event pulse |
| ovf_err_i | input | 1 | Receive overflow event pulse |
| miss_i | input | 1 | Missed-frame event pulse |
| rx_done_i | input | 1 | Receive-done event pulse |
| tx_done_i | input | 1 | Transmit-done event pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read-clear side effect) |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid while reg_rd_i is high |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-module properties check these rules on every cycle:
- a single counter step;
- the rollover and the status bit it sets;
- the read-clear result, including a concurrent event;
- the sticky hold and write-one clear of status bits;
- the silence of irq_o when no enable is set.

Only the bench's scenarios show the rest:
- the packing of fields in the read data;
- the exact cycle of a wrap after 256 events, with all four counters wrapping together;
- a set event winning against a same-cycle clear;
- the mix of enables that raises the interrupt.

The reference model is compared against read data and irq_o every clock.

// File: rtl/rx_err_stats.sv
module rx_err_stats #(
  parameter int CW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crc_err_i,
  input  logic          frame_err_i,
  input  logic          ovf_err_i,
  input  logic          miss_i,
  input  logic          rx_done_i,
  input  logic          tx_done_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam int NCNT = 4;
  localparam int SW   = 6;
  localparam logic [1:0] A_STAT = 2'd0, A_EN = 2'd1, A_ERR = 2'd2, A_MISS = 2'd3;

  logic [NCNT-1:0] ev, clr, wrap;
  logic [CW-1:0]   cnt [NCNT];
  logic [SW-1:0]   st, st_set, st_clr;
  logic [2:0]      en;

  assign ev = {miss_i, ovf_err_i, frame_err_i, crc_err_i};

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    localparam logic [1:0] MY_A = (k == 3) ? A_MISS : A_ERR;
    localparam int SB = (k == 3) ? 2 : k + 3;
    assign clr[k]  = reg_rd_i && reg_addr_i == MY_A;
    assign wrap[k] = ev[k] && !clr[k] && (&cnt[k]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cnt[k] <= '0;
      else if (clr[k]) cnt[k] <= CW'(ev[k]);
      else if (ev[k])  cnt[k] <= cnt[k] + 1'b1;

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[k] && !clr[k] && !(&cnt[k])) |=> cnt[k] == CW'($past(cnt[k]) + 1'b1));
    p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[k] && !clr[k] && (&cnt[k])) |=> (st[SB] && cnt[k] == '0));
    p_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr[k] |=> cnt[k] == CW'($past(ev[k])));
  end

  assign st_set = {wrap[2], wrap[1], wrap[0], wrap[3], tx_done_i, rx_done_i};
  assign st_clr = (reg_wr_i && reg_addr_i == A_STAT) ? reg_wdata_i[SW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= '0;
      en <= '0;
    end else begin
      st <= (st & ~st_clr) | st_set;
      if (reg_wr_i && reg_addr_i == A_EN) en <= reg_wdata_i[2:0];
    end

  assign irq_o = (st[0] & en[0]) | (st[1] & en[1]) | ((|st[5:2]) & en[2]);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i)
      case (reg_addr_i)
        A_STAT: reg_rdata_o[SW-1:0] = st;
        A_EN:   reg_rdata_o[2:0]    = en;
        A_ERR:  reg_rdata_o[3*CW-1:0] = {cnt[2], cnt[1], cnt[0]};
        default: reg_rdata_o[CW-1:0] = cnt[3];
      endcase
  end

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[0] && !rx_done_i) |=> !st[0]);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st[1] && !(reg_wr_i && reg_addr_i == A_STAT)) |=> st[1]);
  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> st[0]);
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 3'b000) |-> !irq_o);
endmodule

// File: tb/rx_err_stats_tb.sv
module rx_err_stats_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic crc, frm, ovf, miss, rxd, txd, wr, rd;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic irq;
  int total = 0, bad = 0;
  int mc[4];
  int mst = 0, men = 0;

  always #5 clk = ~clk;

  rx_err_stats dut_i (
    .clk(clk), .rst_n(rst_n), .crc_err_i(crc), .frame_err_i(frm), .ovf_err_i(ovf),
    .miss_i(miss), .rx_done_i(rxd), .tx_done_i(txd), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic int exp_rd(input int a);
    case (a)
      0: return mst;
      1: return men;
      2: return mc[0] | (mc[1] << 8) | (mc[2] << 16);
      default: return mc[3];
    endcase
  endfunction

  function automatic bit exp_irq();
    return ((mst & 1) && (men & 1)) || ((mst & 2) && (men & 2)) ||
           ((mst & 32'h3C) != 0 && (men & 4));
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic [3:0] e, input logic rx, input logic tx,
                     input logic w, input logic r, input logic [1:0] a, input logic [31:0] d);
    int setb;
    bit clrk;
    {miss, ovf, frm, crc} = e;
    rxd = rx; txd = tx; wr = w; rd = r; addr = a; wdata = d;
    #1;
    if (r) check(req, "rdata", int'(rdata), exp_rd(int'(a)));
    else   check("R9", "rdata idle", int'(rdata), 0);
    @(posedge clk);
    setb = (rx ? 1 : 0) | (tx ? 2 : 0);
    for (int k = 0; k < 4; k++) begin
      clrk = r && (a == ((k == 3) ? 2'd3 : 2'd2));
      if (clrk) mc[k] = e[k] ? 1 : 0;
      else if (e[k]) begin
        if (mc[k] == 255) begin
          mc[k] = 0;
          setb |= 1 << ((k == 3) ? 2 : k + 3);
        end else mc[k]++;
      end
    end
    if (w && a == 2'd0) mst &= ~int'(d[5:0]);
    mst |= setb;
    if (w && a == 2'd1) men = int'(d[2:0]);
    @(negedge clk);
    check("R6", "irq", int'(irq), int'(exp_irq()));
    {miss, ovf, frm, crc, rxd, txd, wr, rd} = '0;
  endtask

  task automatic rdr(input string req, input logic [1:0] a);
    cyc(req, 4'b0, 0, 0, 0, 1, a, 0);
  endtask
  task automatic wrr(input string req, input logic [1:0] a, input logic [31:0] d);
    cyc(req, 4'b0, 0, 0, 1, 0, a, d);
  endtask
  task automatic evt(input string req, input logic [3:0] e);
    cyc(req, e, 0, 0, 0, 0, 2'd0, 0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (mc[i]) mc[i] = 0;
    {crc, frm, ovf, miss, rxd, txd, wr, rd} = '0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8", "irq after reset", int'(irq), 0);
    for (int a = 0; a < 4; a++) rdr("R8", 2'(a));
    wrr("R6", 2'd1, 32'h7);
    rdr("R9", 2'd1);
    for (int i = 0; i < 10; i++)
      evt("R3", {1'b0, i % 3 == 0, i % 2 == 0, 1'b1});
    rdr("R1", 2'd2);
    rdr("R5", 2'd2);
    for (int i = 0; i < 5; i++) evt("R2", 4'b1000);
    rdr("R2", 2'd3);
    for (int i = 0; i < 256; i++) evt("R3", 4'b0001);
    rdr("R3", 2'd0);
    wrr("R4", 2'd0, 32'h0);
    rdr("R4", 2'd0);
    wrr("R4", 2'd0, 32'h8);
    rdr("R4", 2'd0);
    evt("R5", 4'b0001);
    cyc("R5", 4'b0001, 0, 0, 0, 1, 2'd2, 0);
    rdr("R5", 2'd2);
    cyc("R7", 4'b0, 1, 0, 0, 0, 2'd0, 0);
    cyc("R7", 4'b0, 0, 1, 0, 0, 2'd0, 0);
    rdr("R7", 2'd0);
    wrr("R6", 2'd1, 32'h0);
    wrr("R6", 2'd1, 32'h2);
    wrr("R4", 2'd0, 32'h2);
    cyc("R4", 4'b0, 1, 0, 1, 0, 2'd0, 32'h1);
    rdr("R4", 2'd0);
    wrr("R4", 2'd0, 32'h3F);
    wrr("R6", 2'd1, 32'h4);
    for (int i = 0; i < 300; i++) evt("R3", 4'b1111);
    rdr("R3", 2'd0);
    rdr("R1", 2'd2);
    rdr("R2", 2'd3);
    rdr("R5", 2'd3);
    wrr("R4", 2'd0, 32'h14);
    rdr("R4", 2'd0);
    wrr("R4", 2'd0, 32'h3F);
    rdr("R6", 2'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule